// File: doc/BRIEF.md
# UART Hardware Flow Controller (Auto-RTS / Auto-CTS)

This block sits beside the receive and transmit engines of a UART with a 16-entry receive FIFO and handles hardware flow control on its own. On the receive side it decides when the active-low RTS output should tell the far end to pause. It works from the FIFO occupancy, the selected receive trigger level, and events reported by the receiver: a character in progress, the strobe for its first data bit, and reads of the receive buffer. On the transmit side it produces a permit signal. The transmitter must see this signal high before it starts a new character. The permit follows the synchronized, active-low CTS input, which is sampled at the middle of the final stop bit.

Two modem-control bits configure it. With the flow-enable bit set and the RTS bit set, both directions are automatic. With the flow-enable bit set and the RTS bit clear, only the transmit gate is automatic and RTS stays inactive. With the flow-enable bit clear, RTS is simply the inverse of the RTS bit and the transmitter is never held. Automatic RTS changes are delayed by a fixed number of baud-clock ticks before they reach the pin.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, `rtsN` is 1 (inactive) and `txPermit` is 1.
- R2: With `afe` = 0, `rtsN` equals the inverse of `mcrRts` one clock later, and `txPermit` stays 1 whatever `ctsN` does.
- R3: With `afe` = 1 and `mcrRts` = 0, `rtsN` stays 1 regardless of FIFO state, while `txPermit` is governed by CTS.
- R4: With automatic RTS and `trigSel` encoding 0, 1 or 2 (levels 1, 4 and 8), the controller deasserts RTS (`rtsN` = 1) once `fifoCount` reaches the level and not before it.
- R5: For levels 1, 4 and 8, once RTS has been deasserted it stays deasserted while the FIFO drains, and is asserted again only when `fifoCount` reaches 0.
- R6: With `trigSel` = 3 (level 14), RTS is deasserted when `rxFirstBit` pulses while `fifoCount` = 15, that is, on the first data bit of the 16th character.
- R7: For level 14, a held RTS is released when `fifoCount` is 14 or less, or when `fifoCount` = 15 and `rxBusy` is 0. With `fifoCount` = 15 and `rxBusy` = 1 it stays held.
- R8: For level 14, a `rxRead` strobe while `fifoCount` = 16 releases RTS.
- R9: In automatic mode, an internal RTS decision reaches the pin on the third `baudTick` after it changes, and `rtsN` updates one clock after that tick. Earlier ticks leave the pin unchanged.
- R10: With `afe` = 1 and the transmitter busy, `txPermit` falls only on a `txStopMid` strobe that sees CTS inactive. A CTS drop earlier in the character does not affect it, and a strobe with CTS active keeps it high.
- R11: With `afe` = 1 and the transmitter idle, `txPermit` falls when synchronized CTS is inactive. It rises again once CTS is active, after the two-stage input synchronizer and one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoCount | input | 5 | Receive FIFO occupancy, 0 to 16 |
| trigSel | input | 2 | Trigger level: 0=1, 1=4, 2=8, 3=14 bytes |
| rxBusy | input | 1 | A character is being received |
| rxFirstBit | input | 1 | One-cycle strobe at the first data bit of a received character |
| rxRead | input | 1 | One-cycle strobe for a receive-buffer read |
| txBusy | input | 1 | The transmitter is shifting a character |
| txStopMid | input | 1 | One-cycle strobe at the middle of the final stop bit |
| baudTick | input | 1 | Baud-clock enable strobe |
| ctsN | input | 1 | Clear-to-send pin, active low, asynchronous |
| afe | input | 1 | Flow-control enable bit |
| mcrRts | input | 1 | RTS bit of modem control |
| rtsN | output | 1 | Request-to-send pin, active low |
| txPermit | output | 1 | Transmitter may start a new character |

## Verification
Assertions check four rules on every cycle: the permit is held high when flow control is off, the permit cannot drop mid-character without the stop-bit strobe, the release on an empty FIFO and on a read while full, and that the delayed RTS state only moves on a baud tick. The bench's scenarios cover what depends on history and latency. These are the holding of RTS while the FIFO drains through levels 1, 4 and 8, the 16th-character rule at level 14 with and without a character in flight, the exact tick at which the pin moves, and the CTS synchronizer delay. A long random walk of FIFO occupancy and receiver events is compared against a bench model of the release rules.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trigSel_e;

  // Conditions the datapath derives from FIFO level, CTS and its own state
  typedef struct packed {
    logic cntGeTrig;
    logic cntZero;
    logic cntFull;
    logic cntLastSlot;
    logic cntRoom2;
    logic ctsOk;
    logic holdQ;
    logic permitQ;
  } flowFlags_t;

  // Strobes the control sends to the datapath state
  typedef struct packed {
    logic holdSet;
    logic holdClr;
    logic permitSet;
    logic permitClr;
  } flowCtl_t;

  function automatic int unsigned trigLevel(input logic [1:0] sel);
    case (sel)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_flow_dp.sv
module uart_flow_dp
  import uart_flow_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int RTS_DELAY   = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int DLY_W      = $clog2(RTS_DELAY + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [1:0]       trigSel,
  input  logic             ctsN,
  input  logic             baudTick,
  input  logic             autoRts,
  input  logic             mcrRts,
  input  flowCtl_t         ctl,
  output flowFlags_t       flags,
  output logic             rtsN,
  output logic             txPermit
);

  logic [SYNC_STAGES-1:0] ctsPipe;
  logic                   holdQ;
  logic                   shownHold;
  logic [DLY_W-1:0]       dlyCnt;
  logic                   rtsQ;
  logic                   permitQ;

  // CTS synchronizer, reset to inactive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsPipe <= '1;
    end else begin
      for (int i = SYNC_STAGES - 1; i > 0; i--) begin
        ctsPipe[i] <= ctsPipe[i-1];
      end
      ctsPipe[0] <= ctsN;
    end
  end

  // Level comparisons
  always_comb begin
    flags.cntGeTrig   = fifoCount >= CNT_W'(trigLevel(trigSel));
    flags.cntZero     = fifoCount == '0;
    flags.cntFull     = fifoCount == CNT_W'(DEPTH);
    flags.cntLastSlot = fifoCount == CNT_W'(DEPTH - 1);
    flags.cntRoom2    = fifoCount <= CNT_W'(DEPTH - 2);
    flags.ctsOk       = ~ctsPipe[SYNC_STAGES-1];
    flags.holdQ       = holdQ;
    flags.permitQ     = permitQ;
  end

  // Receive hold decision
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= 1'b0;
    end else if (ctl.holdClr) begin
      holdQ <= 1'b0;
    end else if (ctl.holdSet) begin
      holdQ <= 1'b1;
    end
  end

  // Baud-tick delay between the decision and the pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shownHold <= 1'b0;
      dlyCnt    <= '0;
    end else if (!autoRts) begin
      shownHold <= holdQ;
      dlyCnt    <= '0;
    end else if (shownHold == holdQ) begin
      dlyCnt <= '0;
    end else if (baudTick) begin
      if (dlyCnt == DLY_W'(RTS_DELAY - 1)) begin
        shownHold <= holdQ;
        dlyCnt    <= '0;
      end else begin
        dlyCnt <= dlyCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtsQ <= 1'b1;
    end else begin
      rtsQ <= autoRts ? shownHold : ~mcrRts;
    end
  end

  // Transmit permit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      permitQ <= 1'b1;
    end else if (ctl.permitClr) begin
      permitQ <= 1'b0;
    end else if (ctl.permitSet) begin
      permitQ <= 1'b1;
    end
  end

  assign rtsN     = rtsQ;
  assign txPermit = permitQ;

  AST_RTS_TICKED: assert property (@(posedge clk) disable iff (!rstN)
    (autoRts && $past(autoRts) && !$stable(shownHold)) |-> $past(baudTick)); // R9

endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import uart_flow_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  flowFlags_t flags,
  input  logic [1:0] trigSel,
  input  logic       rxBusy,
  input  logic       rxFirstBit,
  input  logic       rxRead,
  input  logic       txBusy,
  input  logic       txStopMid,
  input  logic       afe,
  input  logic       mcrRts,
  output logic       autoRts,
  output flowCtl_t   ctl
);

  logic deepMode;

  assign autoRts  = afe & mcrRts;
  assign deepMode = trigSel == TRIG_14;

  // Receive side: when to hold off the far end
  always_comb begin
    ctl.holdSet = 1'b0;
    ctl.holdClr = 1'b0;
    if (!autoRts) begin
      ctl.holdClr = 1'b1;
    end else if (deepMode) begin
      if (rxRead && flags.cntFull) begin
        ctl.holdClr = 1'b1;
      end else if (rxFirstBit && flags.cntLastSlot) begin
        ctl.holdSet = 1'b1;
      end else if (flags.cntRoom2 || (flags.cntLastSlot && !rxBusy)) begin
        ctl.holdClr = 1'b1;
      end
    end else begin
      if (flags.cntGeTrig) begin
        ctl.holdSet = 1'b1;
      end else if (flags.cntZero) begin
        ctl.holdClr = 1'b1;
      end
    end
  end

  // Transmit side: gate the next character on CTS
  always_comb begin
    ctl.permitSet = 1'b0;
    ctl.permitClr = 1'b0;
    if (!afe) begin
      ctl.permitSet = 1'b1;
    end else if (flags.permitQ) begin
      if (!flags.ctsOk && (txStopMid || !txBusy)) begin
        ctl.permitClr = 1'b1;
      end
    end else if (flags.ctsOk) begin
      ctl.permitSet = 1'b1;
    end
  end

  AST_PERMIT_MANUAL: assert property (@(posedge clk) disable iff (!rstN)
    !afe |=> flags.permitQ); // R2

  AST_PERMIT_MIDCHAR: assert property (@(posedge clk) disable iff (!rstN)
    (afe && flags.permitQ && txBusy && !txStopMid) |=> flags.permitQ); // R10

  AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (autoRts && !deepMode && flags.cntZero) |=> !flags.holdQ); // R5

  AST_FULL_READ: assert property (@(posedge clk) disable iff (!rstN)
    (autoRts && deepMode && rxRead && flags.cntFull) |=> !flags.holdQ); // R8

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uart_flow_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int RTS_DELAY   = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [1:0]       trigSel,
  input  logic             rxBusy,
  input  logic             rxFirstBit,
  input  logic             rxRead,
  input  logic             txBusy,
  input  logic             txStopMid,
  input  logic             baudTick,
  input  logic             ctsN,
  input  logic             afe,
  input  logic             mcrRts,
  output logic             rtsN,
  output logic             txPermit
);

  flowFlags_t flags;
  flowCtl_t   ctl;
  logic       autoRts;

  uart_flow_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .flags      (flags),
    .trigSel    (trigSel),
    .rxBusy     (rxBusy),
    .rxFirstBit (rxFirstBit),
    .rxRead     (rxRead),
    .txBusy     (txBusy),
    .txStopMid  (txStopMid),
    .afe        (afe),
    .mcrRts     (mcrRts),
    .autoRts    (autoRts),
    .ctl        (ctl)
  );

  uart_flow_dp #(
    .DEPTH       (DEPTH),
    .RTS_DELAY   (RTS_DELAY),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fifoCount (fifoCount),
    .trigSel   (trigSel),
    .ctsN      (ctsN),
    .baudTick  (baudTick),
    .autoRts   (autoRts),
    .mcrRts    (mcrRts),
    .ctl       (ctl),
    .flags     (flags),
    .rtsN      (rtsN),
    .txPermit  (txPermit)
  );

endmodule

// File: tb/uart_flow_ctrl_bench.sv
module uart_flow_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] fifoCount = '0;
  logic [1:0] trigSel = '0;
  logic       rxBusy = 1'b0;
  logic       rxFirstBit = 1'b0;
  logic       rxRead = 1'b0;
  logic       txBusy = 1'b0;
  logic       txStopMid = 1'b0;
  logic       baudTick = 1'b1;
  logic       ctsN = 1'b0;
  logic       afe = 1'b0;
  logic       mcrRts = 1'b0;
  logic       rtsN;
  logic       txPermit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_flow_ctrl u_uart_flow_ctrl (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .trigSel(trigSel),
    .rxBusy(rxBusy), .rxFirstBit(rxFirstBit), .rxRead(rxRead),
    .txBusy(txBusy), .txStopMid(txStopMid), .baudTick(baudTick),
    .ctsN(ctsN), .afe(afe), .mcrRts(mcrRts), .rtsN(rtsN), .txPermit(txPermit)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseRead();
    rxRead = 1'b1; cyc(1); rxRead = 1'b0;
  endtask

  task automatic pulseFirst();
    rxFirstBit = 1'b1; cyc(1); rxFirstBit = 1'b0;
  endtask

  task automatic tick();
    baudTick = 1'b1; cyc(1); baudTick = 1'b0; cyc(1);
  endtask

  // Reference for the receive hold decision, built from R4 to R8
  function automatic logic modelHold(input logic hold, input int cnt, input int sel,
                                     input logic busy, input logic first,
                                     input logic rd, input logic auto);
    int lvl;
    if (!auto) return 1'b0;
    if (sel == 3) begin
      if (rd && cnt == 16) return 1'b0;
      if (first && cnt == 15) return 1'b1;
      if (cnt <= 14 || (cnt == 15 && !busy)) return 1'b0;
      return hold;
    end
    lvl = (sel == 0) ? 1 : (sel == 1) ? 4 : 8;
    if (cnt >= lvl) return 1'b1;
    if (cnt == 0) return 1'b0;
    return hold;
  endfunction

  initial begin
    cyc(150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    check("R1 rts after reset", rtsN, 1'b1);
    check("R1 permit after reset", txPermit, 1'b1);

    // R2: manual mode
    mcrRts = 1'b1; cyc(2);
    check("R2 rts follows bit", rtsN, 1'b0);
    ctsN = 1'b1; cyc(6);
    check("R2 permit ignores cts", txPermit, 1'b1);
    mcrRts = 1'b0; cyc(2);
    check("R2 rts follows bit clear", rtsN, 1'b1);

    // R3: auto-CTS only
    afe = 1'b1; fifoCount = 5'd0; cyc(6);
    check("R3 rts inactive", rtsN, 1'b1);
    check("R3 permit held by cts", txPermit, 1'b0);
    ctsN = 1'b0; cyc(5);
    check("R3 permit from cts", txPermit, 1'b1);

    // R4/R5 at level 8
    mcrRts = 1'b1; trigSel = 2'd2; fifoCount = 5'd7; cyc(8);
    check("R4 below level asserted", rtsN, 1'b0);
    fifoCount = 5'd8; cyc(8);
    check("R4 at level deasserted", rtsN, 1'b1);
    fifoCount = 5'd3; pulseRead(); cyc(8);
    check("R5 held while draining", rtsN, 1'b1);
    fifoCount = 5'd0; pulseRead(); cyc(8);
    check("R5 released at empty", rtsN, 1'b0);
    trigSel = 2'd0; fifoCount = 5'd1; cyc(8);
    check("R4 level 1 deasserted", rtsN, 1'b1);
    fifoCount = 5'd0; cyc(8);

    // R6/R7/R8 at level 14
    trigSel = 2'd3; fifoCount = 5'd15; rxBusy = 1'b1; cyc(8);
    check("R7 fifteen stored asserted", rtsN, 1'b0);
    pulseFirst(); cyc(8);
    check("R6 sixteenth first bit", rtsN, 1'b1);
    check("R7 held while busy at 15", rtsN, 1'b1);
    rxBusy = 1'b0; cyc(8);
    check("R7 released idle at 15", rtsN, 1'b0);
    rxBusy = 1'b1; pulseFirst(); fifoCount = 5'd16; rxBusy = 1'b0; cyc(8);
    check("R6 held when full", rtsN, 1'b1);
    pulseRead(); fifoCount = 5'd15; rxBusy = 1'b1; cyc(8);
    check("R8 read at full releases", rtsN, 1'b0);
    rxBusy = 1'b0; fifoCount = 5'd14; cyc(8);
    check("R7 room of two", rtsN, 1'b0);

    // R9: baud-tick delay
    baudTick = 1'b0; trigSel = 2'd1; fifoCount = 5'd4; cyc(4);
    check("R9 no tick no change", rtsN, 1'b0);
    tick(); tick(); cyc(2);
    check("R9 two ticks no change", rtsN, 1'b0);
    tick(); cyc(1);
    check("R9 third tick lands", rtsN, 1'b1);
    baudTick = 1'b1; fifoCount = 5'd0; cyc(8);

    // R10/R11: transmit gating
    txBusy = 1'b1; ctsN = 1'b0; cyc(5);
    check("R10 permit while busy", txPermit, 1'b1);
    ctsN = 1'b1; cyc(6);
    check("R10 mid-char cts drop ignored", txPermit, 1'b1);
    txStopMid = 1'b1; cyc(1); txStopMid = 1'b0; cyc(1);
    check("R10 stop mid drops permit", txPermit, 1'b0);
    txBusy = 1'b0; cyc(4);
    check("R11 stays blocked", txPermit, 1'b0);
    ctsN = 1'b0; cyc(2);
    check("R11 sync latency", txPermit, 1'b0);
    cyc(1);
    check("R11 resumes", txPermit, 1'b1);
    txBusy = 1'b1; txStopMid = 1'b1; cyc(1); txStopMid = 1'b0; cyc(1);
    check("R10 stop mid with cts kept", txPermit, 1'b1);
    txBusy = 1'b0; ctsN = 1'b1; cyc(5);
    check("R11 idle drop", txPermit, 1'b0);
    ctsN = 1'b0; cyc(5);

    // Random walk of receive events against the reference (R4 to R8, R2, R3)
    afe = 1'b0; fifoCount = 5'd0; cyc(4);
    begin
      logic mHold = 1'b0;
      logic prevExp = rtsN;
      int stable = 0;
      int cnt = 0;
      for (int blk = 0; blk < 60; blk++) begin
        afe = ($urandom % 4) != 0;
        mcrRts = ($urandom % 4) != 0;
        trigSel = 2'($urandom % 4);
        for (int c = 0; c < 80; c++) begin
          logic expOut;
          @(negedge clk);
          expOut = (afe && mcrRts) ? mHold : ~mcrRts;
          if (expOut == prevExp) stable++; else stable = 0;
          prevExp = expOut;
          if (stable >= 6) check("R4-style random rts (R5 R7)", rtsN, expOut);
          case ($urandom % 8)
            0, 1: if (cnt < 16) cnt++;
            2:    if (cnt > 0) cnt--;
            default: ;
          endcase
          fifoCount = 5'(cnt);
          rxBusy = $urandom % 2;
          rxFirstBit = ($urandom % 5) == 0;
          rxRead = ($urandom % 6) == 0;
          mHold = modelHold(mHold, cnt, int'(trigSel), rxBusy, rxFirstBit, rxRead,
                            afe && mcrRts);
        end
      end
      rxFirstBit = 1'b0; rxRead = 1'b0;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule